// File: doc/BRIEF.md
# Shortest-Stall-First Thread Ranking Unit

This block orders the threads that share a memory scheduler when a new batch of requests has been formed. The neighbouring marking logic presents the request buffer as a mark bit per entry, together with the thread and bank that each entry belongs to. A single-cycle batch-start pulse tells the unit to take a copy of that picture. The unit then walks the entries one per cycle and counts, for every thread, how many marked requests fall on each bank.

From those counts each thread gets two figures. The first is its heaviest bank load, the largest count it has on any one bank. The second is the sum of its counts over all banks. Threads are ordered by heaviest bank load first, by that sum second, and by thread number last. Threads that have nothing marked go after every thread that does. Only counters, adders and magnitude comparators are used.

The result is one rank per thread, where 0 is the most favoured. The same ranking serves every bank. It is published together with a valid flag and stays frozen until the next batch-start pulse. The request arbiter reads it as a priority term.

Top module: `stall_rank_top`

## Requirements
- R1: While no batch-start pulse arrives, a published ranking and its valid flag do not change, whatever the request inputs do.
- R2: A thread whose heaviest bank load (largest number of its marked requests to any one bank) is smaller receives a numerically smaller rank (0 = most favoured).
- R3: Between threads with equal heaviest bank load, the one with fewer marked requests in total receives the smaller rank.
- R4: Threads equal on both loads are ordered by thread number, the lower number receiving the smaller rank.
- R5: Every thread with no marked request ranks after every thread with at least one; among themselves they follow thread number.
- R6: A valid ranking uses each value 0 to NUM_THREADS-1 exactly once. Thread t occupies bits [t*TID_W +: TID_W] of `rank_o`.
- R7: `rank_valid_o` is low in the cycle after a sampled batch-start pulse. It rises exactly NUM_ENTRIES+2 rising edges after that sampling edge, and `rank_o` changes only at that rise.
- R8: Entries whose mark bit is 0 do not contribute to any count, whatever thread and bank fields they carry.
- R9: Mark, thread and bank inputs are captured at the edge that samples the batch-start pulse. Later changes do not alter that batch's result.
- R10: A batch-start pulse that arrives while a ranking is being computed abandons that computation and starts a new one from the newly captured inputs.
- R11: After reset, `rank_valid_o` is 0 and thread t holds rank t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| batch_start_i | input | 1 | One-cycle pulse: a new batch has been formed |
| mark_i | input | NUM_ENTRIES | Mark bit of each request-buffer entry |
| entry_tid_i | input | NUM_ENTRIES*TID_W | Thread number of entry e at bits [e*TID_W +: TID_W] |
| entry_bank_i | input | NUM_ENTRIES*BID_W | Bank number of entry e at bits [e*BID_W +: BID_W] |
| rank_o | output | NUM_THREADS*TID_W | Rank of each thread, 0 = most favoured |
| rank_valid_o | output | 1 | High while rank_o holds the ranking of the current batch |

## Verification
The ranking is due NUM_ENTRIES+2 rising edges after the edge that samples the batch-start pulse. It takes one scan edge per entry, one edge to register the per-thread loads, and one edge to register the ranks. The bench drives and samples on falling edges. It checks that the valid flag is low one half-cycle after the sampling edge, still low after edge NUM_ENTRIES+1, and high with the expected ranks after edge NUM_ENTRIES+2. The hold, capture and restart tests count their waits from the same edge. The bound checker measures the same latency with its own cycle counter.

// File: rtl/stall_rank_pkg.sv
// Shared definitions for the thread ranking unit.
// Assumes: nothing beyond a synchronous design style.
package stall_rank_pkg;

    // Sequencer phases: waiting, walking entries, reducing loads, ordering.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_SUM  = 2'd2,
        PH_RANK = 2'd3
    } rank_phase_e;

    // Width needed to index n items, never less than one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/stall_rank_ctrl.sv
// Sequencer of the ranking unit. A start pulse restarts it from any phase.
// It then steps through NUM_ENTRIES scan cycles, one reduce cycle and one
// order cycle, and sets the valid flag on the last of these.
// Assumes: start_i is a single-cycle pulse; NUM_ENTRIES >= 2.
module stall_rank_ctrl
    import stall_rank_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    localparam int unsigned IDX_W = idx_width(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             scan_en_o,
    output logic [IDX_W-1:0] scan_idx_o,
    output logic             sum_en_o,
    output logic             rank_en_o,
    output logic             valid_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    rank_phase_e      phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             valid_q;

    // Phase, entry pointer and valid flag advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else if (start_i) begin
            phase_q <= PH_SCAN;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) begin
                        phase_q <= PH_SUM;
                    end
                end
                PH_SUM:  phase_q <= PH_RANK;
                PH_RANK: begin
                    phase_q <= PH_IDLE;
                    valid_q <= 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Strobes for the datapath; a fresh start overrides the late phases.
    always_comb begin
        scan_en_o  = (phase_q == PH_SCAN);
        scan_idx_o = idx_q;
        sum_en_o   = (phase_q == PH_SUM)  && !start_i;
        rank_en_o  = (phase_q == PH_RANK) && !start_i;
        valid_o    = valid_q;
    end

endmodule

// File: rtl/stall_rank_snap.sv
// Batch snapshot: copies the mark, thread and bank fields of every entry on
// the start pulse. It then presents the entry chosen by the scan pointer.
// Assumes: entry fields packed entry 0 in the lowest bits.
module stall_rank_snap
    import stall_rank_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned TID_W       = 2,
    parameter int unsigned BID_W       = 2,
    localparam int unsigned IDX_W = idx_width(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         capture_i,
    input  logic [NUM_ENTRIES-1:0]       mark_i,
    input  logic [NUM_ENTRIES*TID_W-1:0] tid_i,
    input  logic [NUM_ENTRIES*BID_W-1:0] bank_i,
    input  logic [IDX_W-1:0]             idx_i,
    output logic                         cur_mark_o,
    output logic [TID_W-1:0]             cur_tid_o,
    output logic [BID_W-1:0]             cur_bank_o
);

    logic [NUM_ENTRIES-1:0]             mark_q;
    logic [NUM_ENTRIES-1:0][TID_W-1:0]  tid_q;
    logic [NUM_ENTRIES-1:0][BID_W-1:0]  bank_q;

    // Freeze the request picture for the batch being ranked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
            tid_q  <= '0;
            bank_q <= '0;
        end else if (capture_i) begin
            mark_q <= mark_i;
            tid_q  <= tid_i;
            bank_q <= bank_i;
        end
    end

    // Select the entry currently being counted.
    always_comb begin
        cur_mark_o = mark_q[idx_i];
        cur_tid_o  = tid_q[idx_i];
        cur_bank_o = bank_q[idx_i];
    end

endmodule

// File: rtl/stall_rank_counter.sv
// Thread-by-bank load counters. Cleared on the start pulse, then bumped
// once for every marked entry the scan presents.
// Assumes: a count never exceeds NUM_ENTRIES, so CNT_W cannot wrap.
module stall_rank_counter #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_BANKS   = 4,
    parameter int unsigned TID_W       = 2,
    parameter int unsigned BID_W       = 2,
    parameter int unsigned CNT_W       = 5
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        clear_i,
    input  logic                                        scan_en_i,
    input  logic                                        mark_i,
    input  logic [TID_W-1:0]                            tid_i,
    input  logic [BID_W-1:0]                            bank_i,
    output logic [NUM_THREADS-1:0][NUM_BANKS-1:0][CNT_W-1:0] cnt_o
);

    logic bump;
    assign bump = scan_en_i && mark_i && !clear_i;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = bump && (tid_i == TID_W'(t)) && (bank_i == BID_W'(b));

            // One cell: count marked requests of thread t to bank b.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i) begin
                    cnt_o[t][b] <= '0;
                end else if (hit) begin
                    cnt_o[t][b] <= cnt_o[t][b] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/stall_rank_summary.sv
// Reduces each thread's bank counts to its heaviest single-bank load and
// its total load, registered on the reduce strobe.
// Assumes: totals bounded by NUM_ENTRIES, which fits in CNT_W.
module stall_rank_summary #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_BANKS   = 4,
    parameter int unsigned CNT_W       = 5
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        load_i,
    input  logic [NUM_THREADS-1:0][NUM_BANKS-1:0][CNT_W-1:0] cnt_i,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]           peak_o,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]           total_o
);

    logic [NUM_THREADS-1:0][CNT_W-1:0] peak_d;
    logic [NUM_THREADS-1:0][CNT_W-1:0] total_d;

    // Per-thread maximum over banks and sum over banks.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            peak_d[t]  = '0;
            total_d[t] = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cnt_i[t][b] > peak_d[t]) begin
                    peak_d[t] = cnt_i[t][b];
                end
                total_d[t] = total_d[t] + cnt_i[t][b];
            end
        end
    end

    // Hold the reduced loads for the ordering stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_o  <= '0;
            total_o <= '0;
        end else if (load_i) begin
            peak_o  <= peak_d;
            total_o <= total_d;
        end
    end

endmodule

// File: rtl/stall_rank_order.sv
// Orders threads by the key {no-load flag, peak, total, thread number}.
// A smaller key is more favoured. Each thread's rank is the number of
// threads whose key is smaller. Keys are unique because the thread number
// is part of them, so the ranks form a permutation.
// Assumes: NUM_THREADS fits in TID_W bits of rank.
module stall_rank_order #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned TID_W       = 2,
    parameter int unsigned CNT_W       = 5,
    localparam int unsigned KEY_W = 1 + 2*CNT_W + TID_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_i,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0] peak_i,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0] total_i,
    output logic [NUM_THREADS-1:0][TID_W-1:0] rank_o
);

    logic [NUM_THREADS-1:0][KEY_W-1:0] key;
    logic [NUM_THREADS-1:0][TID_W-1:0] rank_d;

    // Build one comparison key per thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_key
        assign key[t] = {(total_i[t] == '0), peak_i[t], total_i[t], TID_W'(t)};
    end

    // Count, for each thread, the threads that beat it.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            rank_d[t] = '0;
            for (int u = 0; u < NUM_THREADS; u++) begin
                rank_d[t] = rank_d[t] + TID_W'(key[u] < key[t]);
            end
        end
    end

    // Publish ranks; reset leaves identity order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                rank_o[t] <= TID_W'(t);
            end
        end else if (load_i) begin
            rank_o <= rank_d;
        end
    end

endmodule

// File: rtl/stall_rank_top.sv
// Shortest-stall-first thread ranking unit. On a batch-start pulse it
// snapshots the request buffer fields and scans one entry per cycle into
// thread-by-bank counters. It then reduces the counters to per-thread loads
// and registers one rank per thread. The ranking is valid NUM_ENTRIES+2
// edges after the pulse and holds until the next pulse.
// Assumes: NUM_THREADS and NUM_BANKS >= 2; start is a one-cycle pulse.
module stall_rank_top
    import stall_rank_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_BANKS   = 4,
    parameter int unsigned NUM_ENTRIES = 16,
    localparam int unsigned TID_W = idx_width(NUM_THREADS),
    localparam int unsigned BID_W = idx_width(NUM_BANKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         batch_start_i,
    input  logic [NUM_ENTRIES-1:0]       mark_i,
    input  logic [NUM_ENTRIES*TID_W-1:0] entry_tid_i,
    input  logic [NUM_ENTRIES*BID_W-1:0] entry_bank_i,
    output logic [NUM_THREADS*TID_W-1:0] rank_o,
    output logic                         rank_valid_o
);

    localparam int unsigned IDX_W = idx_width(NUM_ENTRIES);
    localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 1);

    logic                                              scan_en;
    logic [IDX_W-1:0]                                  scan_idx;
    logic                                              sum_en;
    logic                                              rank_en;
    logic                                              cur_mark;
    logic [TID_W-1:0]                                  cur_tid;
    logic [BID_W-1:0]                                  cur_bank;
    logic [NUM_THREADS-1:0][NUM_BANKS-1:0][CNT_W-1:0]  cnt;
    logic [NUM_THREADS-1:0][CNT_W-1:0]                 peak;
    logic [NUM_THREADS-1:0][CNT_W-1:0]                 total;
    logic [NUM_THREADS-1:0][TID_W-1:0]                 rank_q;

    stall_rank_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (batch_start_i),
        .scan_en_o  (scan_en),
        .scan_idx_o (scan_idx),
        .sum_en_o   (sum_en),
        .rank_en_o  (rank_en),
        .valid_o    (rank_valid_o)
    );

    stall_rank_snap #(
        .NUM_ENTRIES(NUM_ENTRIES), .TID_W(TID_W), .BID_W(BID_W)
    ) snap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (batch_start_i),
        .mark_i     (mark_i),
        .tid_i      (entry_tid_i),
        .bank_i     (entry_bank_i),
        .idx_i      (scan_idx),
        .cur_mark_o (cur_mark),
        .cur_tid_o  (cur_tid),
        .cur_bank_o (cur_bank)
    );

    stall_rank_counter #(
        .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS),
        .TID_W(TID_W), .BID_W(BID_W), .CNT_W(CNT_W)
    ) counter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (batch_start_i),
        .scan_en_i (scan_en),
        .mark_i    (cur_mark),
        .tid_i     (cur_tid),
        .bank_i    (cur_bank),
        .cnt_o     (cnt)
    );

    stall_rank_summary #(
        .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)
    ) summary_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sum_en),
        .cnt_i   (cnt),
        .peak_o  (peak),
        .total_o (total)
    );

    stall_rank_order #(
        .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .CNT_W(CNT_W)
    ) order_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rank_en),
        .peak_i  (peak),
        .total_i (total),
        .rank_o  (rank_q)
    );

    assign rank_o = rank_q;

endmodule

// File: rtl/stall_rank_chk.sv
// Protocol checker for the ranking unit, bound to the top module.
// Assumes: same parameters as the unit it watches.
module stall_rank_chk #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned TID_W       = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         batch_start_i,
    input logic [NUM_THREADS*TID_W-1:0] rank_o,
    input logic                         rank_valid_o
);

    localparam int unsigned LAT    = NUM_ENTRIES + 2;
    localparam int unsigned SINCE_W = $clog2(LAT + 4) + 1;
    localparam logic [SINCE_W-1:0] SINCE_MAX = '1;

    logic [SINCE_W-1:0]     since;
    logic [NUM_THREADS-1:0] seen;

    // Edges elapsed since the last sampled start pulse (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
        end else if (batch_start_i) begin
            since <= SINCE_W'(1);
        end else if (since != '0 && since != SINCE_MAX) begin
            since <= since + 1'b1;
        end
    end

    // Which rank values are present in the output.
    always_comb begin
        seen = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            seen[rank_o[t*TID_W +: TID_W]] = 1'b1;
        end
    end

    assert_rank_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_valid_o && !batch_start_i) |=> (rank_valid_o && $stable(rank_o)));

    assert_rank_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rank_valid_o |-> (&seen));

    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        batch_start_i |=> !rank_valid_o);

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rank_valid_o) |-> (since == SINCE_W'(LAT + 1)));

    assert_rank_moves_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rank_o) |-> $rose(rank_valid_o));

endmodule

bind stall_rank_top stall_rank_chk #(
    .NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .TID_W(TID_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .batch_start_i (batch_start_i),
    .rank_o        (rank_o),
    .rank_valid_o  (rank_valid_o)
);

// File: tb/stall_rank_tb.sv
// Self-checking bench for stall_rank_top with default parameters
// (4 threads, 4 banks, 16 entries). Inputs change and outputs are sampled
// on falling edges.
module stall_rank_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 16;
    localparam int LAT = NE + 2;

    typedef struct packed {
        logic [15:0] mark;
        logic [31:0] tid;
        logic [31:0] bank;
        logic [7:0]  exp_rank;
    } vec_t;

    // Ranks packed {r3,r2,r1,r0}; entry e fields at bits [2e +: 2].
    localparam vec_t VECS [5] = '{
        // all threads one per bank: pure thread-number order (R4)
        '{16'hFFFF, 32'hE4E4E4E4, 32'hFFAA5500, 8'hE4},
        // peaks 2,3,2,1; totals 2,3,3,4; unmarked t0 entries ignored (R2 R3 R8)
        '{16'h0FFF, 32'h00A950FF, 32'h00E950E4, 8'h2D},
        // t0 empty ranks last, t1/t2 tie on peak broken by total (R3 R5)
        '{16'h003F, 32'h00000E95, 32'h00000E90, 8'h1B},
        // nothing marked: all empty, thread-number order (R5 R8)
        '{16'h0000, 32'hFFFFFFFF, 32'h00000000, 8'hE4},
        // pairs with equal loads ordered by thread number (R4)
        '{16'h003F, 32'h00000E50, 32'h00000E44, 8'h4E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        batch_start = 1'b0;
    logic [15:0] mark = '0;
    logic [31:0] tid = '0;
    logic [31:0] bank = '0;
    logic [7:0]  rank;
    logic        rank_valid;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stall_rank_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .batch_start_i (batch_start),
        .mark_i        (mark),
        .entry_tid_i   (tid),
        .entry_bank_i  (bank),
        .rank_o        (rank),
        .rank_valid_o  (rank_valid)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one batch; returns at the falling edge after the sampling edge.
    task automatic start_batch(input vec_t v);
        mark = v.mark;
        tid = v.tid;
        bank = v.bank;
        batch_start = 1'b1;
        @(negedge clk);
        batch_start = 1'b0;
    endtask

    // Check valid timing and the ranks; called just after start_batch.
    task automatic expect_result(input string req, input logic [7:0] exp);
        check_eq("R7 valid low after start", 32'(rank_valid), 0);
        repeat (LAT - 1) @(negedge clk);
        check_eq("R7 valid low one edge early", 32'(rank_valid), 0);
        @(negedge clk);
        check_eq("R7 valid high on time", 32'(rank_valid), 1);
        check_eq(req, 32'(rank), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check_eq("R11 valid after reset", 32'(rank_valid), 0);
        check_eq("R11 identity ranks after reset", 32'(rank), 32'h0E4);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < 5; i++) begin
            start_batch(VECS[i]);
            expect_result($sformatf("R2 R3 R4 R5 R6 R8 table row %0d", i), VECS[i].exp_rank);
            repeat (2) @(negedge clk);
        end

        // R1: ranks hold while inputs wander with no start pulse
        mark = 16'hFFFF;
        tid = 32'h55555555;
        bank = 32'hAAAAAAAA;
        repeat (30) @(negedge clk);
        check_eq("R1 valid held", 32'(rank_valid), 1);
        check_eq("R1 ranks held", 32'(rank), 32'h04E);

        // R9: inputs changed right after capture do not matter
        start_batch(VECS[1]);
        mark = VECS[0].mark;
        tid = VECS[0].tid;
        bank = VECS[0].bank;
        expect_result("R9 captured inputs used", VECS[1].exp_rank);

        // R10: restart mid-computation uses the new inputs
        start_batch(VECS[0]);
        repeat (5) @(negedge clk);
        check_eq("R10 valid low while busy", 32'(rank_valid), 0);
        start_batch(VECS[2]);
        expect_result("R10 restart result", VECS[2].exp_rank);

        // R7: restart landing on the ordering cycle must not publish stale ranks
        start_batch(VECS[4]);
        repeat (LAT - 1) @(negedge clk);
        start_batch(VECS[1]);
        check_eq("R7 no publish on late restart", 32'(rank), 32'(VECS[2].exp_rank));
        expect_result("R7 late restart result", VECS[1].exp_rank);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule